// File: doc/BRIEF.md
# Byte-strobed SRAM write sequencer

This block turns a stream of synchronous write requests into write cycles on an asynchronous static RAM with a 16-bit data bus and separate upper and lower byte strobes. Each request carries an address, one data word and two byte-enable bits. Once a burst starts, chip enable and write enable stay low for every word in it. The two byte strobes alone open and close each word's write. The address and data stay fixed around each strobe pulse for a setup and a hold window, and each window is a parameter counted in clock cycles.

Each word takes SETUP_CYC + STROBE_CYC + HOLD_CYC cycles. In the last hold cycle the block raises its ready output. If a request is waiting at that point, the next word follows with no gap and write enable stays low. If no request is waiting, the burst ends: write enable and chip enable go high and the data bus goes to high impedance. Output enable is held high at all times, so the memory never drives the shared bus.

Top module: `sram_burst_writer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `mem_ce_n`, `mem_we_n`, `mem_ub_n` and `mem_lb_n` are high, `mem_dq` is high impedance and `req_ready` is high. A reset applied during a burst abandons it after one clock edge.
- R2: `mem_oe_n` is high in every cycle, whether the block is idle, writing or in reset.
- R3: A request is taken on the clock edge where `req_valid` and `req_ready` are both high. From the next cycle, `mem_ce_n` and `mem_we_n` are low and `mem_addr` and `mem_dq` carry the request's address and data. Both strobes stay high for the first SETUP_CYC cycles of the word.
- R4: After the setup window, the strobe of each lane whose byte-enable bit is 1 is low for exactly STROBE_CYC cycles. `req_be[1]` controls `mem_ub_n` (bits 15:8) and `req_be[0]` controls `mem_lb_n` (bits 7:0).
- R5: A lane whose byte-enable bit is 0 keeps its strobe high for the whole word, including when both bits are 0.
- R6: After the strobes rise, address and data stay unchanged for HOLD_CYC more cycles. A word lasts SETUP_CYC+STROBE_CYC+HOLD_CYC cycles.
- R7: `req_ready` is high when the block is idle and in the last hold cycle of a word, and low in every other cycle of a word.
- R8: If a request is waiting in the last hold cycle, the next word's address and data appear in the following cycle with `mem_we_n` and `mem_ce_n` still low.
- R9: If no request is waiting in the last hold cycle, the next cycle has `mem_we_n`, `mem_ce_n` and both strobes high and `mem_dq` released.
- R10: While idle with `req_valid` low, all control lines stay high and the bus stays released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A write request is present |
| req_ready | output | 1 | The block takes the request on this edge if valid |
| req_addr | input | AW | Word address of the request |
| req_data | input | DW | Data word of the request |
| req_be | input | 2 | Byte enables: bit 1 upper lane, bit 0 lower lane |
| mem_addr | output | AW | Address to the memory |
| mem_dq | inout | DW | Memory data bus; driven only during a burst |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low, held high |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |

## Verification
All memory-side outputs are registered. Each one changes in the cycle right after the edge that takes a request or ends a phase. The bench treats that edge as cycle 0 of a word and checks every output on each falling edge for cycle indices 0 to SETUP_CYC+STROBE_CYC+HOLD_CYC-1. It works out the expected strobe level from the index and the byte-enable bits. The next request goes onto the inputs at the cycle-0 falling edge, so it is waiting when ready rises in the last hold cycle. The idle state is checked one falling edge after that word's last cycle.

// File: rtl/sram_burst_writer.sv
module sram_burst_writer #(
  parameter int AW         = 17,
  parameter int DW         = 16,
  parameter int SETUP_CYC  = 2,
  parameter int STROBE_CYC = 3,
  parameter int HOLD_CYC   = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic [1:0]    req_be,
  output logic [AW-1:0] mem_addr,
  inout  wire  [DW-1:0] mem_dq,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_ub_n,
  output logic          mem_lb_n
);

  localparam int LONGEST = (SETUP_CYC > STROBE_CYC) ?
                           ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
                           ((STROBE_CYC > HOLD_CYC) ? STROBE_CYC : HOLD_CYC);
  localparam int CW = (LONGEST < 2) ? 1 : $clog2(LONGEST);
  localparam logic [CW-1:0] SU_LAST = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] ST_LAST = CW'(STROBE_CYC - 1);
  localparam logic [CW-1:0] HD_LAST = CW'(HOLD_CYC - 1);

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_t;

  phase_t        ph, ph_nx;
  logic [CW-1:0] cnt, last_cnt;
  logic          at_end, take;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [1:0]    be_q, be_nx;
  logic          drive_q, ce_q, we_q, ub_q, lb_q;

  always_comb begin
    case (ph)
      PH_SETUP:  last_cnt = SU_LAST;
      PH_STROBE: last_cnt = ST_LAST;
      PH_HOLD:   last_cnt = HD_LAST;
      default:   last_cnt = '0;
    endcase
  end

  assign at_end    = (cnt == last_cnt);
  assign req_ready = (ph == PH_IDLE) || (ph == PH_HOLD && at_end);
  assign take      = req_valid && req_ready;
  assign be_nx     = take ? req_be : be_q;

  always_comb begin
    ph_nx = ph;
    case (ph)
      PH_IDLE:   if (take)   ph_nx = PH_SETUP;
      PH_SETUP:  if (at_end) ph_nx = PH_STROBE;
      PH_STROBE: if (at_end) ph_nx = PH_HOLD;
      PH_HOLD:   if (at_end) ph_nx = take ? PH_SETUP : PH_IDLE;
      default:   ph_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= PH_IDLE;
      cnt     <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      be_q    <= '0;
      drive_q <= 1'b0;
      ce_q    <= 1'b1;
      we_q    <= 1'b1;
      ub_q    <= 1'b1;
      lb_q    <= 1'b1;
    end else begin
      ph  <= ph_nx;
      cnt <= (ph_nx != ph || ph == PH_IDLE || take) ? '0 : cnt + 1'b1;
      if (take) begin
        addr_q <= req_addr;
        data_q <= req_data;
        be_q   <= req_be;
      end
      drive_q <= (ph_nx != PH_IDLE);
      ce_q    <= (ph_nx == PH_IDLE);
      we_q    <= (ph_nx == PH_IDLE);
      ub_q    <= !(ph_nx == PH_STROBE && be_nx[1]);
      lb_q    <= !(ph_nx == PH_STROBE && be_nx[0]);
    end
  end

  assign mem_addr = addr_q;
  assign mem_dq   = drive_q ? data_q : {DW{1'bz}};
  assign mem_ce_n = ce_q;
  assign mem_we_n = we_q;
  assign mem_ub_n = ub_q;
  assign mem_lb_n = lb_q;
  assign mem_oe_n = 1'b1;

  // A strobe may only fall inside an open chip-enable and write-enable window (R4)
  p_strobe_inside_write_r4: assert property (@(posedge clk) disable iff (rst)
    (!mem_ub_n || !mem_lb_n) |-> (!mem_we_n && !mem_ce_n && drive_q));

  // Address and data frozen from strobe fall through hold (R6)
  p_word_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_STROBE || ph == PH_HOLD) |-> ($stable(addr_q) && $stable(data_q)));

  // Strobes rise before the address may move (R6)
  p_strobe_rise_before_next_r6: assert property (@(posedge clk) disable iff (rst)
    (!mem_ub_n || !mem_lb_n) |=> (ph != PH_SETUP));

  // Ready only in idle or on the final hold cycle (R7)
  p_ready_window_r7: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_we_n || (ph == PH_HOLD && mem_ub_n && mem_lb_n)));

  // Back-to-back: a request taken in hold keeps write enable low (R8)
  p_we_held_r8: assert property (@(posedge clk) disable iff (rst)
    (take && !mem_we_n) |=> (!mem_we_n && !mem_ce_n));

  // Idle lines all inactive and bus released (R9)
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_IDLE) |-> (mem_we_n && mem_ce_n && mem_ub_n && mem_lb_n && !drive_q));

endmodule

// File: tb/sim_sram_burst_writer.sv
`timescale 1ns/1ps
module sim_sram_burst_writer;
  localparam int AW = 17;
  localparam int DW = 16;
  localparam int S  = 2;
  localparam int P  = 3;
  localparam int H  = 1;
  localparam int W  = S + P + H;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [1:0]    req_be = '0;
  logic [AW-1:0] mem_addr;
  wire  [DW-1:0] mem_dq;
  logic          mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [AW-1:0] wa [8];
  logic [DW-1:0] wd [8];
  logic [1:0]    wb [8];

  always #2.5 clk = ~clk;

  sram_burst_writer #(.AW(AW), .DW(DW), .SETUP_CYC(S), .STROBE_CYC(P), .HOLD_CYC(H)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_be(req_be),
    .mem_addr(mem_addr), .mem_dq(mem_dq), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_quiet(string tag);
    chk({tag, " ce_n"}, 32'(mem_ce_n), 32'd1);
    chk({tag, " we_n"}, 32'(mem_we_n), 32'd1);
    chk({tag, " ub_n"}, 32'(mem_ub_n), 32'd1);
    chk({tag, " lb_n"}, 32'(mem_lb_n), 32'd1);
    chk({tag, " dq"}, {16'h0, mem_dq}, {16'h0, 16'hzzzz});
    chk({tag, " ready"}, 32'(req_ready), 32'd1);
    chk("R2 oe_n idle", 32'(mem_oe_n), 32'd1);
  endtask

  task automatic check_cycle(int i, int k);
    logic on;
    on = (k >= S) && (k < S + P);
    chk(i == 0 ? "R3 ce_n" : "R8 ce_n", 32'(mem_ce_n), 32'd0);
    chk(i == 0 ? "R3 we_n" : "R8 we_n", 32'(mem_we_n), 32'd0);
    chk(k >= S + P ? "R6 addr hold" : "R3 addr", 32'(mem_addr), 32'(wa[i]));
    chk(k >= S + P ? "R6 data hold" : "R3 data", {16'h0, mem_dq}, {16'h0, wd[i]});
    chk(wb[i][1] ? "R4 ub_n" : "R5 ub_n", 32'(mem_ub_n), 32'(!(on && wb[i][1])));
    chk(wb[i][0] ? "R4 lb_n" : "R5 lb_n", 32'(mem_lb_n), 32'(!(on && wb[i][0])));
    chk("R7 ready", 32'(req_ready), 32'(k == W - 1));
    chk("R2 oe_n busy", 32'(mem_oe_n), 32'd1);
  endtask

  task automatic do_burst(int n);
    @(negedge clk);
    chk("R7 ready idle", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_addr = wa[0]; req_data = wd[0]; req_be = wb[0];
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < W; k++) begin
        @(negedge clk);
        if (k == 0) begin
          if (i + 1 < n) begin
            req_addr = wa[i+1]; req_data = wd[i+1]; req_be = wb[i+1];
          end else req_valid = 1'b0;
        end
        check_cycle(i, k);
      end
    end
    @(negedge clk);
    check_quiet("R9 end");
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check_quiet("R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    check_quiet("R1 after reset");
  endtask

  task automatic t_idle;
    req_valid = 1'b0;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      check_quiet("R10 idle");
    end
  endtask

  task automatic t_single;
    wa[0] = 17'h1A5C3; wd[0] = 16'hBEEF; wb[0] = 2'b11;
    do_burst(1);
  endtask

  task automatic t_burst;
    wa[0] = 17'h00010; wd[0] = 16'h1234; wb[0] = 2'b11;
    wa[1] = 17'h00011; wd[1] = 16'h5678; wb[1] = 2'b10;
    wa[2] = 17'h1FFFF; wd[2] = 16'h9ABC; wb[2] = 2'b01;
    wa[3] = 17'h00000; wd[3] = 16'hDEF0; wb[3] = 2'b00;
    do_burst(4);
  endtask

  task automatic t_gap;
    wa[0] = 17'h0AAAA; wd[0] = 16'h00FF; wb[0] = 2'b01;
    do_burst(1);
    t_idle();
    wa[0] = 17'h15555; wd[0] = 16'hFF00; wb[0] = 2'b10;
    do_burst(1);
  endtask

  task automatic t_reset_mid;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 17'h00123; req_data = 16'hA5A5; req_be = 2'b11;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (S + 1) @(negedge clk);
    chk("R4 mid strobe low", 32'(mem_ub_n), 32'd0);
    rst = 1'b1;
    @(negedge clk);
    check_quiet("R1 reset mid burst");
    rst = 1'b0;
    @(negedge clk);
    check_quiet("R1 after mid reset");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_idle();
    t_single();
    t_burst();
    t_gap();
    t_reset_mid();
    t_single();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule